// File: doc/BRIEF.md
# Configuration Request Bus-Window Router

This block sits on the downstream side of a bridge or switch port. It decides where each ID-routed configuration request goes. Request packets arrive one 32-bit DW per beat on a valid/ready stream, and the final beat of each packet is marked. The block first collects the three header DWs. It then reads the Type field of DW0 and the target bus number in DW2, and compares that bus number with a Secondary/Subordinate bus window. The window is captured at the moment the first header DW is accepted.

A Type 1 configuration request has one of three outcomes:
- It leaves as Type 0 when it targets the Secondary bus.
- It passes unchanged when it targets a bus further down inside the window.
- It is swallowed when it falls outside the window. No error completion is produced, and the discard raises a one-cycle pulse and bumps a saturating counter.

Every other packet, including Type 0 configuration requests, passes unmodified with a bypass flag set so that another routing unit can take it. The header is only released once the decision is made. Any data DW follows on the same packet without gaps being reordered or lost under backpressure.

Top module: `cfg_id_router`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `drop_pulse` is 0 and `drop_count` is 0.
- R2: The Type field is DW0 bits [28:24]. Only the value 5'b00101 (Type 1 configuration) is routed through the bus window. Every other packet, including Type 0 configuration (5'b00100), leaves with all beats unchanged and `out_bypass` high on each beat.
- R3: A Type 1 request whose target bus (DW2 bits [31:24]) equals the Secondary value leaves with DW0 bit 24 cleared. All other bits and all other beats are unchanged, and `out_bypass` is low.
- R4: A Type 1 request with Secondary < bus <= Subordinate leaves with every beat unchanged and `out_bypass` low.
- R5: A Type 1 request whose bus is neither equal to Secondary nor inside (Secondary, Subordinate] produces no output beat at all. This covers its data DW if it has one.
- R6: Each discarded request raises `drop_pulse` for exactly one cycle. While below its maximum, `drop_count` rises by one per discard.
- R7: `drop_count` saturates at 2^CNT_W-1 and stays there.
- R8: Output beats keep input order, and `out_last` marks the last beat of each packet. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold.
- R9: `sec_bus` and `sub_bus` are sampled when DW0 of a packet is accepted. Later changes do not affect that packet's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_bus | input | BUS_W | Secondary bus number of this port |
| sub_bus | input | BUS_W | Subordinate bus number of this port |
| in_valid | input | 1 | Upstream beat valid |
| in_data | input | DW | Upstream DW |
| in_last | input | 1 | Last beat of the upstream packet |
| in_ready | output | 1 | Block accepts the upstream beat |
| out_valid | output | 1 | Downstream beat valid |
| out_data | output | DW | Downstream DW |
| out_last | output | 1 | Last beat of the downstream packet |
| out_bypass | output | 1 | Beat belongs to a non-routed (bypassed) packet |
| out_ready | input | 1 | Downstream accepts the beat |
| drop_pulse | output | 1 | One-cycle strobe per discarded request |
| drop_count | output | CNT_W | Saturating discard count |

## Verification
The router is driven with Type 1 requests whose target bus is placed on each edge of the window. The edges used are Secondary, Secondary+1, Subordinate, Subordinate+1 and Secondary-1, plus an empty window where Subordinate is below Secondary. These placements separate conversion from forwarding from discard, and catch an off-by-one or an equality/inequality swap in the window compare.

Reads of three beats and writes of four beats are mixed with Type 0 and non-configuration packets of random length. This shows that only bit 24 of DW0 changes and that data DWs travel or vanish with their header. Random output stalls and input gaps exercise the hold rule. A directed case rewrites the window right after DW0 is taken, which shows the decision used the earlier values. A run of more than fifteen discards, with a narrow counter, shows the saturation.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [1:0] {
    ACT_BYPASS  = 2'd0,
    ACT_CONVERT = 2'd1,
    ACT_FORWARD = 2'd2,
    ACT_DISCARD = 2'd3
  } route_act_e;

  localparam logic [4:0] TYPE_CFG_T1 = 5'b00101;

  // Routing decision for one request header.
  function automatic route_act_e route_decide(input logic [4:0] typ,
                                              input logic [7:0] bus,
                                              input logic [7:0] sec,
                                              input logic [7:0] sub);
    if (typ != TYPE_CFG_T1)              return ACT_BYPASS;
    else if (bus == sec)                 return ACT_CONVERT;
    else if ((bus > sec) && (bus <= sub)) return ACT_FORWARD;
    else                                 return ACT_DISCARD;
  endfunction

  // Type 1 -> Type 0: only DW0 bit 24 (Type bit 0) changes.
  function automatic logic [31:0] to_type0(input logic [31:0] dw0);
    return {dw0[31:25], 1'b0, dw0[23:0]};
  endfunction

endpackage

// File: rtl/cfgr_hdr_buf.sv
module cfgr_hdr_buf #(
  parameter int DW      = 32,
  parameter int BUS_W   = 8,
  parameter int HDR_DWS = 3,
  localparam int IDX_W  = $clog2(HDR_DWS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic [DW-1:0]                cap_data,
  input  logic [BUS_W-1:0]             sec_in,
  input  logic [BUS_W-1:0]             sub_in,
  output logic [HDR_DWS-1:0][DW-1:0]   hdr_q,
  output logic [BUS_W-1:0]             sec_q,
  output logic [BUS_W-1:0]             sub_q,
  output logic                         cap_final
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_DWS - 1);

  logic [IDX_W-1:0] idx;

  assign cap_final = cap_en && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (cap_en) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  // Window is latched with the first header word (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (cap_en && (idx == '0)) begin
      sec_q <= sec_in;
      sub_q <= sub_in;
    end
  end

  for (genvar g = 0; g < HDR_DWS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) hdr_q[g] <= '0;
      else if (cap_en && (idx == IDX_W'(g))) hdr_q[g] <= cap_data;
    end
  end

endmodule

// File: rtl/cfgr_route_decide.sv
module cfgr_route_decide
  import cfgr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic [4:0]       typ,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec,
  input  logic [BUS_W-1:0] sub,
  output route_act_e       act
);
  assign act = route_decide(typ, 8'(bus), 8'(sec), 8'(sub));
endmodule

// File: rtl/cfgr_drop_cnt.sv
module cfgr_drop_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_evt,
  output logic             drop_pulse,
  output logic [CNT_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_pulse <= 1'b0;
      drop_count <= '0;
    end else begin
      drop_pulse <= drop_evt;
      if (drop_evt && (drop_count != CNT_MAX)) drop_count <= drop_count + CNT_ONE;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && (drop_count != CNT_MAX)) |=> (drop_count == $past(drop_count) + CNT_ONE)); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !drop_pulse); // R6

endmodule

// File: rtl/cfg_id_router.sv
module cfg_id_router
  import cfgr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 16,
  parameter int HDR_DWS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             out_bypass,
  input  logic             out_ready,
  output logic             drop_pulse,
  output logic [CNT_W-1:0] drop_count
);
  localparam int IDX_W   = $clog2(HDR_DWS);
  localparam int BUS_LSB = DW - BUS_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_DWS - 1);

  typedef enum logic [1:0] {S_HDR, S_EMIT, S_BODY, S_DROP} st_e;

  st_e                       st;
  logic [HDR_DWS-1:0][DW-1:0] hdr_q;
  logic [BUS_W-1:0]          sec_q, sub_q;
  logic                      cap_en, cap_final;
  route_act_e                act_now, act_q;
  logic                      hdr_last_q;
  logic [IDX_W-1:0]          emit_idx;
  logic [DW-1:0]             emit_word;
  logic                      drop_evt;

  assign cap_en   = (st == S_HDR) && in_valid;
  assign drop_evt = cap_final && (act_now == ACT_DISCARD);

  cfgr_hdr_buf #(.DW(DW), .BUS_W(BUS_W), .HDR_DWS(HDR_DWS)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_data(in_data),
    .sec_in(sec_bus), .sub_in(sub_bus), .hdr_q(hdr_q),
    .sec_q(sec_q), .sub_q(sub_q), .cap_final(cap_final)
  );

  // Decision uses DW0 already held and the bus byte of DW2 being taken now.
  cfgr_route_decide #(.BUS_W(BUS_W)) u_dec (
    .typ(hdr_q[0][28:24]), .bus(in_data[DW-1:BUS_LSB]),
    .sec(sec_q), .sub(sub_q), .act(act_now)
  );

  cfgr_drop_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt),
    .drop_pulse(drop_pulse), .drop_count(drop_count)
  );

  always_comb begin
    emit_word = hdr_q[emit_idx];
    if ((emit_idx == '0) && (act_q == ACT_CONVERT)) emit_word = to_type0(hdr_q[0]);
  end

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    out_last  = 1'b0;
    unique case (st)
      S_HDR:  in_ready = 1'b1;
      S_EMIT: begin
        out_valid = 1'b1;
        out_data  = emit_word;
        out_last  = (emit_idx == LAST_IDX) && hdr_last_q;
      end
      S_BODY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_last  = in_last;
      end
      S_DROP: in_ready = 1'b1;
      default: ;
    endcase
  end

  assign out_bypass = ((st == S_EMIT) || (st == S_BODY)) && (act_q == ACT_BYPASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HDR;
      act_q      <= ACT_BYPASS;
      hdr_last_q <= 1'b0;
      emit_idx   <= '0;
    end else begin
      unique case (st)
        S_HDR: if (cap_final) begin
          act_q      <= act_now;
          hdr_last_q <= in_last;
          emit_idx   <= '0;
          if (act_now == ACT_DISCARD) st <= in_last ? S_HDR : S_DROP;
          else                        st <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          if (emit_idx == LAST_IDX) begin
            emit_idx <= '0;
            st       <= hdr_last_q ? S_HDR : S_BODY;
          end else begin
            emit_idx <= emit_idx + 1'b1;
          end
        end
        S_BODY: if (in_valid && out_ready && in_last) st <= S_HDR;
        S_DROP: if (in_valid && in_last) st <= S_HDR;
        default: st <= S_HDR;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !out_valid); // R5
  AST_EMIT_STALLS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EMIT) |-> !in_ready); // R8
  AST_CONV_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_EMIT) && (emit_idx == '0) && (act_q == ACT_CONVERT)) |-> (out_data[28:24] == 5'b00100)); // R3

endmodule

// File: tb/cfg_id_router_bench.sv
module cfg_id_router_bench;
  localparam int CW = 4;
  localparam int MAXE = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sec_bus = 8'd3, sub_bus = 8'd5;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, out_bypass, drop_pulse;
  logic [31:0] out_data;
  logic [CW-1:0] drop_count;

  int errors = 0, checks = 0;
  int exp_wr = 0, exp_rd = 0, exp_drops = 0, seen_pulses = 0;
  logic [31:0] exp_data [MAXE];
  logic        exp_last [MAXE];
  logic        exp_byp  [MAXE];
  string       exp_tag  [MAXE];
  bit prev_pulse = 0;
  bit stall_en = 1;

  always #5 clk = ~clk;

  cfg_id_router #(.CNT_W(CW)) u_cfg_id_router (
    .clk(clk), .rst_n(rst_n), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_bypass(out_bypass), .out_ready(out_ready),
    .drop_pulse(drop_pulse), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 convert, 1 forward, 2 discard, 3 bypass
  function automatic int model_route(input logic [31:0] w0, input logic [7:0] bus,
                                     input logic [7:0] s, input logic [7:0] u);
    if (w0[28:24] != 5'h05) return 3;
    if (bus == s) return 0;
    if (bus > s && !(bus > u)) return 1;
    return 2;
  endfunction

  task automatic push(input logic [31:0] d, input logic l, input logic b, input string t);
    exp_data[exp_wr] = d; exp_last[exp_wr] = l; exp_byp[exp_wr] = b; exp_tag[exp_wr] = t;
    exp_wr++;
  endtask

  task automatic drive_beat(input logic [31:0] d, input logic l);
    bit acc;
    in_valid = 1'b1; in_data = d; in_last = l;
    forever begin
      #4; acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                          input int n_pay, input bit poke, input string tag_in);
    int r;
    string t;
    logic [31:0] pay [4];
    r = model_route(w0, w2[31:24], sec_bus, sub_bus);
    for (int i = 0; i < 4; i++) pay[i] = $urandom;
    if (tag_in != "") t = tag_in;
    else t = (r == 0) ? "R3" : (r == 1) ? "R4" : "R2";
    if (r == 2) exp_drops++;
    else begin
      push((r == 0) ? (w0 & ~32'h0100_0000) : w0, 1'b0, r == 3, t);
      push(w1, 1'b0, r == 3, t);
      push(w2, n_pay == 0, r == 3, t);
      for (int i = 0; i < n_pay; i++) push(pay[i], i == n_pay - 1, r == 3, t);
    end
    repeat ($urandom % 2) @(negedge clk);
    drive_beat(w0, 1'b0);
    if (poke) begin sec_bus = sec_bus + 8'd7; sub_bus = sec_bus; end
    drive_beat(w1, 1'b0);
    drive_beat(w2, n_pay == 0);
    for (int i = 0; i < n_pay; i++) drive_beat(pay[i], i == n_pay - 1);
  endtask

  function automatic logic [31:0] mk_w0(input logic [4:0] typ, input bit wr);
    logic [31:0] w;
    w = $urandom;
    w[31:29] = wr ? 3'b010 : 3'b000;
    w[28:24] = typ;
    return w;
  endfunction

  function automatic logic [31:0] mk_w2(input logic [7:0] bus);
    logic [31:0] w;
    w = $urandom;
    w[31:24] = bus;
    return w;
  endfunction

  task automatic cfg1(input logic [7:0] bus, input bit wr);
    send_pkt(mk_w0(5'h05, wr), $urandom, mk_w2(bus), wr ? 1 : 0, 1'b0, "");
  endtask

  task automatic drain;
    int guard = 0;
    while (exp_rd != exp_wr && guard < 2000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    check(exp_rd == exp_wr, "R5", "pending expected beats", 32'(exp_wr - exp_rd), 32'd0);
  endtask

  // Sink and monitor
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
      #4;
      if (rst_n) begin
        if (drop_pulse) seen_pulses++;
        if (drop_pulse && prev_pulse) check(0, "R6", "pulse longer than one cycle", 32'd1, 32'd0);
        prev_pulse = drop_pulse;
        if (out_valid && out_ready) begin
          if (exp_rd >= exp_wr) check(0, "R5", "unexpected output beat", out_data, 32'd0);
          else begin
            check(out_data == exp_data[exp_rd], exp_tag[exp_rd], "data", out_data, exp_data[exp_rd]);
            check(out_last == exp_last[exp_rd], "R8", "last", 32'(out_last), 32'(exp_last[exp_rd]));
            check(out_bypass == exp_byp[exp_rd], "R2", "bypass", 32'(out_bypass), 32'(exp_byp[exp_rd]));
            exp_rd++;
          end
        end
      end
    end
  end

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #4;
    check(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
    check(drop_pulse == 1'b0, "R1", "drop_pulse", 32'(drop_pulse), 32'd0);
    check(drop_count == '0, "R1", "drop_count", 32'(drop_count), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Window edges with sec=3 sub=5
    sec_bus = 8'd3; sub_bus = 8'd5;
    cfg1(8'd3, 0); cfg1(8'd3, 1);     // R3
    cfg1(8'd4, 1); cfg1(8'd5, 0);     // R4
    cfg1(8'd6, 0); cfg1(8'd2, 1);     // R5
    cfg1(8'd0, 0);                    // R5
    send_pkt(mk_w0(5'h04, 1), $urandom, mk_w2(8'd3), 1, 1'b0, "R2");  // Type 0 bypass
    send_pkt(mk_w0(5'h00, 1), $urandom, mk_w2(8'd9), 3, 1'b0, "R2");  // non-config
    // Empty window (sub < sec)
    sec_bus = 8'd9; sub_bus = 8'd4;
    cfg1(8'd9, 0); cfg1(8'd10, 1); cfg1(8'd4, 0);
    // R9: window changes right after DW0 accepted
    sec_bus = 8'd20; sub_bus = 8'd30;
    send_pkt(mk_w0(5'h05, 0), $urandom, mk_w2(8'd25), 0, 1'b1, "R9");
    sec_bus = 8'd40; sub_bus = 8'd40;
    send_pkt(mk_w0(5'h05, 1), $urandom, mk_w2(8'd40), 1, 1'b1, "R9");
    drain();
    check(seen_pulses == exp_drops, "R6", "pulse count", 32'(seen_pulses), 32'(exp_drops));
    check(drop_count == CW'(exp_drops), "R6", "drop_count", 32'(drop_count), 32'(exp_drops));

    // Random mix
    for (int p = 0; p < 300; p++) begin
      int k;
      logic [7:0] bus;
      if (p % 25 == 0) begin sec_bus = $urandom % 200; sub_bus = sec_bus + ($urandom % 6); end
      k = $urandom % 8;
      case (k)
        0: bus = sec_bus;
        1: bus = sec_bus + 8'd1;
        2: bus = sub_bus;
        3: bus = sub_bus + 8'd1;
        4: bus = sec_bus - 8'd1;
        default: bus = $urandom;
      endcase
      if (($urandom % 4) == 0)
        send_pkt(mk_w0(($urandom % 2) ? 5'h04 : 5'h00, 1'b0), $urandom, mk_w2(bus),
                 $urandom % 4, 1'b0, "R2");
      else cfg1(bus, $urandom % 2);
    end
    drain();
    check(seen_pulses == exp_drops, "R6", "pulse count after mix", 32'(seen_pulses), 32'(exp_drops));

    // R7: force saturation
    stall_en = 0;
    sec_bus = 8'd50; sub_bus = 8'd60;
    for (int i = 0; i < 20; i++) cfg1(8'd61 + 8'(i), i % 2);
    drain();
    check(drop_count == {CW{1'b1}}, "R7", "saturated drop_count",
          32'(drop_count), 32'((1 << CW) - 1));
    check(seen_pulses == exp_drops, "R6", "pulses past saturation", 32'(seen_pulses), 32'(exp_drops));
    cfg1(8'd50, 1);
    drain();
    summary();
  end

endmodule